// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital front end of a four-channel serial DAC. Four slow control pins arrive from off chip: a serial clock, a serial data line, a latch strobe and a commit strobe. Each pin passes through a two-flop synchroniser into the system clock domain. Falling edges are then found by comparing each synchronised pin with its value one sample earlier.

The serial data is sampled on every falling edge of the serial clock. Eleven bits make one command, sent most significant bit first. Within a command, the two earliest bits name the target channel (0 to 3), the next bit is the gain flag (0 for x1, 1 for x2), and the remaining eight bits are the unsigned code.

Updates happen in two stages. A falling edge on the latch pin writes the most recently completed command into the holding register of the channel it names. A falling edge on the commit pin copies all four holding registers to the output registers at the same moment, and raises a one-cycle update strobe.

Top module: `qdac_cmd_rx`

## Requirements
- R1: After reset, all four output codes are 0, all gain outputs are 0 (x1), `upd_o` is low, and the bit counter is at zero.
- R2: A serial bit is captured on each falling edge of `sclk_i`, most significant bit first. In an 11-bit command w[10:0], w[10:9] is the channel index, w[8] is the gain flag and w[7:0] is the code.
- R3: The bit counter returns to zero after the eleventh bit. Back-to-back commands decode independently, and only the last completed command is kept.
- R4: A falling edge on `latch_i` writes the last completed command's code and gain into the holding register of the channel it names. The outputs do not change on that edge.
- R5: A falling edge on `commit_i` copies all four holding registers (code and gain) to the outputs in the same cycle. `upd_o` pulses high for exactly one cycle for each such edge.
- R6: When latch and commit fall in the same sample, the latch is applied first, so the committed outputs already contain the value just latched.
- R7: When a latch falls in the same sample as the eleventh serial clock fall, the latch uses the previously completed command. The new command becomes the latest only after that.
- R8: Rising edges and changes of `sdata_i` without a serial clock fall have no effect. A commit with no latch since the previous commit leaves the outputs unchanged.
- R9: The gain flag of a committed channel appears on that channel's bit of `out_gain_o` (1 = x2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| latch_i | input | 1 | Latch strobe, acts on its falling edge |
| commit_i | input | 1 | Commit strobe, acts on its falling edge |
| out_code_o | output | 32 | Output codes; channel i is at bits [8i+7:8i] |
| out_gain_o | output | 4 | Gain flag per channel, 1 = x2 |
| upd_o | output | 1 | One-cycle pulse when the outputs are refreshed |

## Verification
Three events can fall together: a latch, a commit and the final serial clock fall of a command. Same-sample cases are created by driving those pins low in the same system clock cycle. All pins pass through the same synchroniser depth, so the falling edges are seen in one sample. A bench model then applies the events in a fixed order: latch, then commit, then shift. The outputs are compared against that model. The cases of latch with commit and of latch with the final shift are each forced directly, and are also mixed into the random commands.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  parameter int unsigned QD_CHANS  = 4;
  parameter int unsigned QD_CODE_W = 8;
  localparam int unsigned QD_SEL_W  = $clog2(QD_CHANS);
  localparam int unsigned QD_WORD_W = QD_SEL_W + 1 + QD_CODE_W;
  localparam int unsigned QD_CNT_W  = $clog2(QD_WORD_W);

  typedef struct packed {
    logic                 gain;
    logic [QD_CODE_W-1:0] code;
  } qd_chan_t;

  typedef struct packed {
    logic [QD_SEL_W-1:0] sel;
    qd_chan_t            val;
  } qd_cmd_t;

  // Split a received word: channel on top, then gain, then code.
  function automatic qd_cmd_t qd_decode(input logic [QD_WORD_W-1:0] w);
    qd_cmd_t c;
    c.sel      = w[QD_WORD_W-1 -: QD_SEL_W];
    c.val.gain = w[QD_CODE_W];
    c.val.code = w[QD_CODE_W-1:0];
    return c;
  endfunction

  function automatic logic qd_last_bit(input logic [QD_CNT_W-1:0] cnt);
    return cnt == QD_CNT_W'(QD_WORD_W - 1);
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdac_edge.sv
module qdac_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift
  import qdac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_evt,
  input  logic                bit_i,
  output logic                word_done,
  output logic [QD_CNT_W-1:0] bit_cnt,
  output qd_cmd_t             cmd_o
);
  logic [QD_WORD_W-2:0] sr_q;
  logic [QD_CNT_W-1:0]  cnt_q;
  qd_cmd_t              cmd_q;

  assign word_done = shift_evt && qd_last_bit(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
    end else if (shift_evt) begin
      sr_q <= {sr_q[QD_WORD_W-3:0], bit_i};
      if (word_done) begin
        cnt_q <= '0;
        cmd_q <= qd_decode({sr_q, bit_i});
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign bit_cnt = cnt_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_evt,
  input  logic     ldac_evt,
  input  qd_cmd_t  cmd_i,
  output qd_chan_t hold_o [QD_CHANS],
  output qd_chan_t out_o  [QD_CHANS],
  output logic     upd_o
);
  qd_chan_t hold_q [QD_CHANS];
  qd_chan_t hold_d [QD_CHANS];
  qd_chan_t out_q  [QD_CHANS];
  logic     upd_q;

  generate
    for (genvar i = 0; i < QD_CHANS; i++) begin : g_chan
      // Latch is resolved before commit within one sample.
      always_comb begin
        hold_d[i] = hold_q[i];
        if (load_evt && cmd_i.sel == QD_SEL_W'(i)) hold_d[i] = cmd_i.val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q[i] <= '0;
          out_q[i]  <= '0;
        end else begin
          hold_q[i] <= hold_d[i];
          if (ldac_evt) out_q[i] <= hold_d[i];
        end
      end

      assign hold_o[i] = hold_q[i];
      assign out_o[i]  = out_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= ldac_evt;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
  import qdac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk_i,
  input  logic                          sdata_i,
  input  logic                          latch_i,
  input  logic                          commit_i,
  output logic [QD_CHANS*QD_CODE_W-1:0] out_code_o,
  output logic [QD_CHANS-1:0]           out_gain_o,
  output logic                          upd_o
);
  localparam int unsigned NPIN = 4;

  logic [NPIN-1:0] pins_s;
  logic [2:0]      falls;
  logic            shift_evt, load_evt, ldac_evt, word_done;
  logic [QD_CNT_W-1:0] bit_cnt;
  qd_cmd_t         cmd;
  qd_chan_t        hold [QD_CHANS];
  qd_chan_t        outs [QD_CHANS];
  logic [QD_CHANS*QD_CODE_W-1:0] hold_code_flat;

  qdac_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sclk_i, sdata_i, latch_i, commit_i}),
    .sync_o(pins_s)
  );

  qdac_edge #(.W(3)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({pins_s[3], pins_s[1], pins_s[0]}),
    .fall_o(falls)
  );

  assign shift_evt = falls[2];
  assign load_evt  = falls[1];
  assign ldac_evt  = falls[0];

  qdac_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_evt(shift_evt), .bit_i(pins_s[2]),
    .word_done(word_done), .bit_cnt(bit_cnt), .cmd_o(cmd)
  );

  qdac_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .load_evt(load_evt), .ldac_evt(ldac_evt), .cmd_i(cmd),
    .hold_o(hold), .out_o(outs), .upd_o(upd_o)
  );

  generate
    for (genvar i = 0; i < QD_CHANS; i++) begin : g_flat
      assign out_code_o[i*QD_CODE_W +: QD_CODE_W]     = outs[i].code;
      assign out_gain_o[i]                            = outs[i].gain;
      assign hold_code_flat[i*QD_CODE_W +: QD_CODE_W] = hold[i].code;
    end
  endgenerate
endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk
  import qdac_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          load_evt,
  input logic                          ldac_evt,
  input logic                          word_done,
  input logic [QD_CNT_W-1:0]           bit_cnt,
  input logic [QD_CHANS*QD_CODE_W-1:0] hold_code_flat,
  input logic [QD_CHANS*QD_CODE_W-1:0] out_code_o,
  input logic                          upd_o
);
  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_reset_chk: assert (bit_cnt == '0);
  end

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> bit_cnt == '0);

  // R5
  upd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_evt |=> upd_o);

  // R5
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(ldac_evt));

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !$past(load_evt)) |-> out_code_o == $past(hold_code_flat));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(out_code_o));
endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .load_evt(load_evt), .ldac_evt(ldac_evt),
  .word_done(word_done), .bit_cnt(bit_cnt),
  .hold_code_flat(hold_code_flat),
  .out_code_o(out_code_o), .upd_o(upd_o)
);

// File: tb/qdac_cmd_rx_tb.sv
module qdac_cmd_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, sdata = 1'b0, latch = 1'b1, commit = 1'b1;
  logic [31:0] out_code;
  logic [3:0]  out_gain;
  logic        upd;

  int n_chk = 0, n_bad = 0, upd_seen = 0, exp_upd = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  m_hcode [4], m_ocode [4];
  logic        m_hgain [4], m_ogain [4];
  logic [10:0] m_sr, m_last;
  int          m_cnt;

  always #10 clk = ~clk;

  qdac_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .latch_i(latch), .commit_i(commit),
    .out_code_o(out_code), .out_gain_o(out_gain), .upd_o(upd)
  );

  always @(posedge clk) if (rst_n && upd) upd_seen++;

  function automatic int f_ch(input logic [10:0] w);
    return int'(w >> 9);
  endfunction
  function automatic logic f_gain(input logic [10:0] w);
    return ((w >> 8) & 11'd1) != 0;
  endfunction
  function automatic logic [7:0] f_code(input logic [10:0] w);
    return 8'(w % 256);
  endfunction
  function automatic logic [10:0] mk(input int ch, input logic g, input logic [7:0] c);
    return 11'(ch * 512 + (g ? 256 : 0) + c);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(tag, int'(out_code[i*8 +: 8]), int'(m_ocode[i]));
      chk(tag, int'(out_gain[i]), int'(m_ogain[i]));
    end
    chk({tag, " upd count"}, upd_seen, exp_upd);
  endtask

  // Drive the requested pins low in one cycle, then model in order latch, commit, shift.
  task automatic fire(input bit do_l, input bit do_c, input bit do_s);
    @(negedge clk);
    if (do_l) latch = 1'b0;
    if (do_c) commit = 1'b0;
    if (do_s) sclk = 1'b0;
    repeat (4) @(negedge clk);
    if (do_l) begin
      m_hcode[f_ch(m_last)] = f_code(m_last);
      m_hgain[f_ch(m_last)] = f_gain(m_last);
    end
    if (do_c) begin
      for (int i = 0; i < 4; i++) begin
        m_ocode[i] = m_hcode[i];
        m_ogain[i] = m_hgain[i];
      end
      exp_upd++;
    end
    if (do_s) begin
      m_sr = {m_sr[9:0], sdata};
      m_cnt++;
      if (m_cnt == 11) begin
        m_last = m_sr;
        m_cnt  = 0;
      end
    end
    latch = 1'b1; commit = 1'b1; sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [10:0] w, input int n);
    for (int i = 10; i > 10 - n; i--) begin
      @(negedge clk);
      sdata = w[i];
      fire(1'b0, 1'b0, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] w;
    int          r;
    void'($urandom(32'h1d5));
    for (int i = 0; i < 4; i++) begin
      m_hcode[i] = '0; m_ocode[i] = '0; m_hgain[i] = 1'b0; m_ogain[i] = 1'b0;
    end
    m_sr = '0; m_last = '0; m_cnt = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_all("R1 reset");
    chk("R1 upd low", int'(upd), 0);

    // R2 / R4 / R5 / R9: single command, latch, then commit
    send_bits(mk(2, 1'b1, 8'hA5), 11);
    fire(1'b1, 1'b0, 1'b0);
    chk_all("R4 latch only");
    fire(1'b0, 1'b1, 1'b0);
    chk_all("R5 commit");
    chk("R2 ch2 code", int'(out_code[23:16]), 8'hA5);
    chk("R9 ch2 gain", int'(out_gain[2]), 1);

    // R3: two back-to-back commands, only the second is latched
    send_bits(mk(1, 1'b0, 8'h3C), 11);
    send_bits(mk(3, 1'b0, 8'h81), 11);
    fire(1'b1, 1'b0, 1'b0);
    fire(1'b0, 1'b1, 1'b0);
    chk_all("R3 back-to-back");
    chk("R3 ch1 untouched", int'(out_code[15:8]), 0);

    // R6: latch and commit in one sample
    send_bits(mk(0, 1'b1, 8'h7E), 11);
    fire(1'b1, 1'b1, 1'b0);
    chk_all("R6 latch+commit");
    chk("R6 ch0 code", int'(out_code[7:0]), 8'h7E);

    // R7: latch together with the final serial fall
    send_bits(mk(1, 1'b0, 8'h11), 11);
    w = mk(1, 1'b1, 8'h99);
    send_bits(w, 10);
    @(negedge clk);
    sdata = w[0];
    fire(1'b1, 1'b0, 1'b1);
    fire(1'b0, 1'b1, 1'b0);
    chk_all("R7 latch on last bit");
    chk("R7 ch1 old word", int'(out_code[15:8]), 8'h11);
    fire(1'b1, 1'b1, 1'b0);
    chk("R7 ch1 new word", int'(out_code[15:8]), 8'h99);

    // R8: data toggles alone, and a repeated commit with no latch
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sdata = ~sdata;
      repeat (4) @(negedge clk);
    end
    fire(1'b0, 1'b1, 1'b0);
    chk_all("R8 no effect");
    fire(1'b1, 1'b1, 1'b0);
    chk_all("R8 count kept");

    // random commands mixed with the orderings above
    for (int it = 0; it < 60; it++) begin
      w = 11'($urandom);
      r = int'($urandom % 5);
      if (r == 4) begin
        send_bits(w, 10);
        @(negedge clk);
        sdata = w[0];
        fire(1'b1, ($urandom % 2) == 1, 1'b1);
      end else begin
        send_bits(w, 11);
        case (r)
          0: fire(1'b1, 1'b0, 1'b0);
          1: fire(1'b0, 1'b1, 1'b0);
          2: fire(1'b1, 1'b1, 1'b0);
          default: begin
            fire(1'b1, 1'b0, 1'b0);
            fire(1'b0, 1'b1, 1'b0);
          end
        endcase
      end
      chk_all("R2/R4/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule